// File: doc/BRIEF.md
# Keypad Matrix Column Scanner

This block reads a sixteen-key switch matrix of four rows and four columns and keeps a sixteen-bit map of which keys are held down. A divided-down tick sets how long each column is driven. One column at a time is pulled low while the other three float. The four row lines are held high by pull-ups on the board, so a row that reads low means the key at that row and that column is closed.

When a column's drive time ends, the four row values are stored, inverted, into the key-map bits that belong to that column. Each bit is indexed by the hex value printed on the key, not by its position in the matrix. Driving then moves to the next column, in the order 0, 1, 2, 3, after which the sequence repeats. Every column is refreshed once per full scan.

The column pins take only two values: driven low, or high impedance. A one-hot enable output shows which column pin is being driven, for pad logic and for observation. The reset is active low and asynchronous. Debouncing, ghost rejection and encoding the map into a key code are left to logic downstream.

Top module: `kp_scan`

## Requirements
- R1: While `rst_n` is low, `keys` is all zeros and column 0 is selected (`col_drv` = 4'b0001). After release, the first scan tick comes N+1 clocks later.
- R2: The internal scan tick is high for exactly one clock in every N+1 clocks, where N is a parameter (default 300000).
- R3: At all times exactly one bit of `col_drv` is 1. The `col` pin with that index is driven to 0 and the other three `col` pins are high impedance.
- R4: The selected column changes only on a scan tick. Each tick moves it from column c to column (c+1) mod 4, so `col_drv` rotates left by one.
- R5: On a scan tick with column c selected, row r (0 to 3) is stored inverted into key bit K(c,r), with rows listed 0 to 3. Column 0 maps to keys 1, 4, 7, 0. Column 1 maps to keys 2, 5, 8, 15. Column 2 maps to keys 3, 6, 9, 14. Column 3 maps to keys 10, 11, 12, 13.
- R6: On a clock without a tick, `keys` does not change. On a tick, only the four bits of the selected column can change.
- R7: After any change in which keys are held, `keys` equals the held set (bit k = 1 while key k is pressed) no later than one full scan (4·(N+1) clocks) after the change. A released key reads 0 within the same bound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row | input | 4 | Row lines from the matrix, pulled high, low when a key in the driven column is closed |
| col | output | 4 | Column lines: the selected column is driven to 0, the others are high impedance |
| col_drv | output | 4 | One-hot flag, high for the column currently driven low |
| keys | output | 16 | Map of held keys, bit k for the key labelled with hex value k |

## Verification
Storing the row sample for a column and moving the drive to the next column happen on the same tick edge. The stored value must therefore come from the rows seen under the old column, not the new one. The bench models the keypad by pulling rows low only while the pressed key's column is driven. It changes the held keys at intervals that do not divide evenly into the tick period, so over the run the changes land before, on and just after a tick. Every clock, a behavioural model compares the key map and the column drive. After each change, a separate check confirms that the map has settled within one full scan.

// File: rtl/kp_pkg.sv
// Package: constants and the key-label map shared by the keypad scanner.
// Assumes a 4x4 matrix; the map ties (column,row) to the printed hex label.
package kp_pkg;
    localparam int KP_ROWS = 4;
    localparam int KP_COLS = 4;
    localparam int KP_KEYS = KP_ROWS * KP_COLS;
    localparam int KP_SELW = $clog2(KP_COLS);
    localparam int KP_IDXW = $clog2(KP_KEYS);

    typedef logic [KP_SELW-1:0] kp_sel_t;
    typedef logic [KP_IDXW-1:0] kp_idx_t;

    // Hex label of the key at a given column and row.
    function automatic kp_idx_t key_index(input kp_sel_t c, input logic [1:0] r);
        kp_idx_t v;
        case ({c, r})
            4'b00_00: v = 4'h1;
            4'b00_01: v = 4'h4;
            4'b00_10: v = 4'h7;
            4'b00_11: v = 4'h0;
            4'b01_00: v = 4'h2;
            4'b01_01: v = 4'h5;
            4'b01_10: v = 4'h8;
            4'b01_11: v = 4'hF;
            4'b10_00: v = 4'h3;
            4'b10_01: v = 4'h6;
            4'b10_10: v = 4'h9;
            4'b10_11: v = 4'hE;
            4'b11_00: v = 4'hA;
            4'b11_01: v = 4'hB;
            4'b11_10: v = 4'hC;
            default:  v = 4'hD;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/kp_tick.sv
// Module: kp_tick
// Free-running divider that raises a one-clock tick once every N+1 clocks.
// Assumes N >= 1; the counter is sized from N.
module kp_tick #(
    parameter int N = 300000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (N < 2) ? 1 : $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N);

    logic [CW-1:0] cnt_q;

    // Count up to LAST, then wrap and fire the tick for one clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/kp_seq.sv
// Module: kp_seq
// Column selector: steps through columns 0..COLS-1 in order, one per tick.
// Assumes COLS is a power of two so the counter wraps naturally.
module kp_seq
    import kp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    output kp_sel_t sel
);
    // Advance to the next column on each tick; hold otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (tick) begin
            sel <= sel + 1'b1;
        end
    end
endmodule

// File: rtl/kp_capture.sv
// Module: kp_capture
// Key-map register: on a tick, stores the inverted rows of the selected
// column into that column's bits by printed label. Assumes rows are active low.
module kp_capture
    import kp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  kp_sel_t            sel,
    input  logic [KP_ROWS-1:0] row,
    output logic [KP_KEYS-1:0] keys
);
    // Refresh the four bits of the column whose drive time ends now.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keys <= '0;
        end else if (tick) begin
            for (int r = 0; r < KP_ROWS; r++) begin
                keys[key_index(sel, 2'(r))] <= ~row[r];
            end
        end
    end
endmodule

// File: rtl/kp_scan.sv
// Module: kp_scan (top)
// Scans a 4x4 keypad: one column pulled low at a time, the rest floating,
// and the rows of each column latched into a 16-bit held-key map.
// Assumes external pull-ups on the rows; no debounce or ghost rejection.
module kp_scan
    import kp_pkg::*;
#(
    parameter int N = 300000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [KP_ROWS-1:0] row,
    output logic [KP_COLS-1:0] col,
    output logic [KP_COLS-1:0] col_drv,
    output logic [KP_KEYS-1:0] keys
);
    logic    tick;
    kp_sel_t sel;

    kp_tick #(.N(N)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    kp_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .sel   (sel)
    );

    kp_capture u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .sel   (sel),
        .row   (row),
        .keys  (keys)
    );

    // Open-drain style column pins: drive 0 when selected, float otherwise.
    for (genvar c = 0; c < KP_COLS; c++) begin : g_col
        assign col_drv[c] = (sel == KP_SELW'(c));
        assign col[c]     = col_drv[c] ? 1'b0 : 1'bz;
    end
endmodule

// File: rtl/kp_scan_chk.sv
// Module: kp_scan_chk
// Property checker for kp_scan, bound into every instance of it.
module kp_scan_chk
    import kp_pkg::*;
#(
    parameter int N = 300000
) (
    input logic               clk,
    input logic               rst_n,
    input logic [KP_ROWS-1:0] row,
    input logic [KP_COLS-1:0] col_drv,
    input logic [KP_KEYS-1:0] keys,
    input logic               tick,
    input kp_sel_t            sel
);
    logic [31:0] gap_q;

    // Clocks since the last tick (or since reset), for the period check.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    gap_q <= '0;
        else if (tick) gap_q <= 32'd1;
        else           gap_q <= gap_q + 32'd1;
    end

    p_tick_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == 32'(N + 1)));

    p_tick_late_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= 32'(N + 1));

    p_one_column_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_drv) == 1);

    p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (col_drv == {$past(col_drv[KP_COLS-2:0]), $past(col_drv[KP_COLS-1])}));

    p_hold_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(col_drv));

    p_keys_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(keys));

    for (genvar r = 0; r < KP_ROWS; r++) begin : g_cap
        p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> (keys[key_index($past(sel), 2'(r))] == !$past(row[r])));
    end
endmodule

bind kp_scan kp_scan_chk #(.N(N)) u_chk (.*);

// File: tb/kp_scan_tb_top.sv
// Bench for kp_scan: keypad model on the rows, behavioural reference
// compared every clock, plus settle checks after each change of held keys.
module kp_scan_tb_top;
    localparam int N     = 7;
    localparam int PER   = N + 1;
    localparam int SCAN  = 4 * PER;
    localparam int WDOG  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  row_w;
    wire  [3:0]  col_w;
    logic [3:0]  col_drv;
    logic [15:0] keys;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;

    logic [15:0] press_mask = '0;

    // Independent label table: rows 0..3 for each column.
    int kmap [4][4] = '{'{1, 4, 7, 0}, '{2, 5, 8, 15}, '{3, 6, 9, 14}, '{10, 11, 12, 13}};

    // Reference model state.
    int          edges_m;
    int          col_m;
    logic [15:0] keys_m;

    always #5 clk = ~clk;

    kp_scan #(.N(N)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .row     (row_w),
        .col     (col_w),
        .col_drv (col_drv),
        .keys    (keys)
    );

    // Keypad model: a pressed key pulls its row low while its column is driven.
    always_comb begin
        for (int r = 0; r < 4; r++) begin
            row_w[r] = 1'b1;
            for (int c = 0; c < 4; c++) begin
                if (col_drv[c] && press_mask[kmap[c][r]]) row_w[r] = 1'b0;
            end
        end
    end

    // Reference: ticks fall after every PER completed clocks since reset.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges_m <= 0;
            col_m   <= 0;
            keys_m  <= '0;
        end else begin
            edges_m <= edges_m + 1;
            if (edges_m > 0 && (edges_m % PER) == 0) begin
                for (int r = 0; r < 4; r++) keys_m[kmap[col_m][r]] <= ~row_w[r];
                col_m <= (col_m + 1) % 4;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check(keys == keys_m, "R5/R6 key map vs model", 32'(keys), 32'(keys_m));
            check(col_drv == 4'(1 << col_m), "R2/R4 column select vs model", 32'(col_drv), 32'(1 << col_m));
            check($countones(col_drv) == 1 && col_w[col_m] == 1'b0, "R3 one column driven low",
                  32'(col_drv), 32'(1 << col_m));
        end
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Change the held set, give one full scan plus one clock, then check.
    task automatic press_and_check(input logic [15:0] m, input string req);
        press_mask = m;
        wait_clks(SCAN + 1);
        check(keys == m, req, 32'(keys), 32'(m));
        wait_clks(5);
    endtask

    initial begin
        @(negedge clk);
        wait_clks(3);
        check(keys == 16'h0000, "R1 keys cleared in reset", 32'(keys), 32'h0);
        check(col_drv == 4'b0001, "R1 column 0 in reset", 32'(col_drv), 32'h1);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1: no tick before N+1 clocks: column 0 held through the first N clocks.
        wait_clks(N);
        check(col_drv == 4'b0001, "R1 first tick not early", 32'(col_drv), 32'h1);
        wait_clks(2);
        check(col_drv == 4'b0010, "R1 first tick after N+1 clocks", 32'(col_drv), 32'h2);

        for (int k = 0; k < 16; k++) begin
            press_and_check(16'(1 << k), "R7 single key settles");
            press_and_check(16'h0000, "R7 release clears");
        end
        press_and_check(16'h0082, "R7 two keys same column");
        press_and_check(16'h1020, "R7 two keys different columns");
        press_and_check(16'h0020, "R7 one of two released");

        // R1: reset mid-scan with a key held.
        press_mask = 16'h8000;
        wait_clks(SCAN + 3);
        rst_n = 1'b0;
        #1;
        check(keys == 16'h0000, "R1 async reset clears keys", 32'(keys), 32'h0);
        check(col_drv == 4'b0001, "R1 async reset selects column 0", 32'(col_drv), 32'h1);
        wait_clks(2);
        rst_n = 1'b1;
        press_and_check(16'h8000, "R7 recovers after reset");
        press_and_check(16'h0000, "R7 final release");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < WDOG; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule